// File: doc/BRIEF.md
# Decode-Stage Operand Bypass Selector

This block supplies the two source operands of the instruction sitting in the decode stage of a five-stage in-order pipeline. For each operand it chooses between the value read from the register file and a result that a later, still-unretired instruction is about to write. Five results can stand in for the register file: the execute stage's fresh result, the load value and the ALU result held in the memory stage, and the load value and the ALU result held in the write-back stage.

When several in-flight instructions target the same register, the youngest one wins, so the decode stage sees the value that strictly sequential execution would give it. Operand A has one extra rule: for a call or a jump it carries the incremented PC, because that is the value those instructions pass down the pipeline. Register ID 0xF means "no register" and never takes part in a match, so a missing operand or a cancelled conditional move cannot pick up a stale result. The block is purely combinational. Stall detection, the register file and the ALU are outside it.

Top module: `operand_bypass`

## Requirements
- R1: When the decode opcode equals CALL (0x8) or JUMP (0x7), operand A equals the decode incremented PC, whatever the register IDs and bypass values are.
- R2: In all other cases, operand A is chosen by comparing the A source ID with the bypass destination IDs. The first match wins, checked in this order: execute result, memory load value, memory ALU result, write-back load value, write-back ALU result.
- R3: When more than one bypass destination equals the source ID, the value from the stage closest to decode is used.
- R4: When no bypass destination equals the source ID, the operand equals the register file read data for that port.
- R5: Register ID 0xF never produces a match. A source ID of 0xF always yields the register file data, even when some destination ID is also 0xF.
- R6: Operand B uses the same five-way priority with the B source ID. It has no PC rule, so a call or jump opcode leaves B forwarded as usual.
- R7: An execute-stage destination of 0xF, as presented by a cancelled conditional move, forwards nothing. A later-stage match or the register file data is used instead.
- R8: Both operands follow their inputs with no clock and no stored state. A new input set is reflected on the outputs in the same time step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dec_op | input | 4 | Opcode of the instruction in decode |
| dec_pc_inc | input | 64 | Incremented PC of the instruction in decode |
| dec_src_a | input | 4 | Register ID of source A |
| dec_src_b | input | 4 | Register ID of source B |
| rf_a | input | 64 | Register file read data, port A |
| rf_b | input | 64 | Register file read data, port B |
| ex_dst | input | 4 | Execute destination ID (0xF if the move is cancelled) |
| ex_res | input | 64 | Execute ALU result |
| mem_dst_ld | input | 4 | Memory-stage load destination ID |
| mem_ld | input | 64 | Memory-stage loaded value |
| mem_dst_alu | input | 4 | Memory-stage ALU destination ID |
| mem_alu | input | 64 | Memory-stage ALU result |
| wb_dst_ld | input | 4 | Write-back load destination ID |
| wb_ld | input | 64 | Write-back loaded value |
| wb_dst_alu | input | 4 | Write-back ALU destination ID |
| wb_alu | input | 64 | Write-back ALU result |
| opnd_a | output | 64 | Selected operand A |
| opnd_b | output | 64 | Selected operand B |

## Verification
Both operands are due zero cycles after a stimulus, because nothing in the path is registered. The bench applies each input set on the falling clock edge and samples the operands one time unit later, well before the next edge. No check relies on state carried over from an earlier input set. Random IDs are drawn from a narrow range that includes 0xF, so that multiple matches, cancelled execute moves and "no register" cases all occur often. Directed cases then pin down each rung of the priority order.

// File: rtl/operand_bypass.sv
module operand_bypass #(
  parameter int DW = 64,
  parameter int RW = 4,
  parameter logic [3:0] OP_JUMP = 4'h7,
  parameter logic [3:0] OP_CALL = 4'h8
) (
  input  logic [3:0]    dec_op,
  input  logic [DW-1:0] dec_pc_inc,
  input  logic [RW-1:0] dec_src_a,
  input  logic [RW-1:0] dec_src_b,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic [RW-1:0] ex_dst,
  input  logic [DW-1:0] ex_res,
  input  logic [RW-1:0] mem_dst_ld,
  input  logic [DW-1:0] mem_ld,
  input  logic [RW-1:0] mem_dst_alu,
  input  logic [DW-1:0] mem_alu,
  input  logic [RW-1:0] wb_dst_ld,
  input  logic [DW-1:0] wb_ld,
  input  logic [RW-1:0] wb_dst_alu,
  input  logic [DW-1:0] wb_alu,
  output logic [DW-1:0] opnd_a,
  output logic [DW-1:0] opnd_b
);

  localparam logic [RW-1:0] NOREG = {RW{1'b1}};

  logic          pc_pass;
  logic [DW-1:0] fwd_a, fwd_b;

  assign pc_pass = (dec_op == OP_CALL) || (dec_op == OP_JUMP);

  function automatic logic [DW-1:0] pick(input logic [RW-1:0] src, input logic [DW-1:0] rfv);
    if (src == NOREG)            return rfv;
    else if (src == ex_dst)      return ex_res;
    else if (src == mem_dst_ld)  return mem_ld;
    else if (src == mem_dst_alu) return mem_alu;
    else if (src == wb_dst_ld)   return wb_ld;
    else if (src == wb_dst_alu)  return wb_alu;
    else                         return rfv;
  endfunction

  assign fwd_a  = pick(dec_src_a, rf_a);
  assign fwd_b  = pick(dec_src_b, rf_b);
  assign opnd_a = pc_pass ? dec_pc_inc : fwd_a;
  assign opnd_b = fwd_b;

  always_comb begin
    if (pc_pass)
      AST_PC_ON_A: assert (opnd_a == dec_pc_inc) else $error("pc pass"); // R1
    if (!pc_pass && dec_src_a != NOREG && dec_src_a == ex_dst)
      AST_EX_FIRST: assert (opnd_a == ex_res) else $error("ex first"); // R3
    if (!pc_pass && dec_src_a == dec_src_b && rf_a == rf_b)
      AST_SAME_CHAIN: assert (opnd_a == opnd_b) else $error("chains differ"); // R6
    if (dec_src_b == NOREG)
      AST_NOREG_B: assert (opnd_b == rf_b) else $error("noreg b"); // R5
    if (!pc_pass && dec_src_a == NOREG)
      AST_NOREG_A: assert (opnd_a == rf_a) else $error("noreg a"); // R5
    if (dec_src_b != NOREG && dec_src_b != ex_dst && dec_src_b != mem_dst_ld &&
        dec_src_b != mem_dst_alu && dec_src_b != wb_dst_ld && dec_src_b != wb_dst_alu)
      AST_NO_HIT_RF: assert (opnd_b == rf_b) else $error("no hit"); // R4
  end

endmodule

// File: tb/operand_bypass_tb.sv
module operand_bypass_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [3:0]  dec_op, dec_src_a, dec_src_b;
  logic [63:0] dec_pc_inc, rf_a, rf_b;
  logic [3:0]  ex_dst, mem_dst_ld, mem_dst_alu, wb_dst_ld, wb_dst_alu;
  logic [63:0] ex_res, mem_ld, mem_alu, wb_ld, wb_alu;
  logic [63:0] opnd_a, opnd_b;

  int checks = 0, errors = 0;
  bit done = 0;

  operand_bypass u_dut (
    .dec_op(dec_op), .dec_pc_inc(dec_pc_inc), .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
    .rf_a(rf_a), .rf_b(rf_b), .ex_dst(ex_dst), .ex_res(ex_res),
    .mem_dst_ld(mem_dst_ld), .mem_ld(mem_ld), .mem_dst_alu(mem_dst_alu), .mem_alu(mem_alu),
    .wb_dst_ld(wb_dst_ld), .wb_ld(wb_ld), .wb_dst_alu(wb_dst_alu), .wb_alu(wb_alu),
    .opnd_a(opnd_a), .opnd_b(opnd_b)
  );

  function automatic logic [63:0] model(input logic [3:0] src, input logic [63:0] rfv);
    logic [3:0]  ids  [5];
    logic [63:0] vals [5];
    ids  = '{ex_dst, mem_dst_ld, mem_dst_alu, wb_dst_ld, wb_dst_alu};
    vals = '{ex_res, mem_ld, mem_alu, wb_ld, wb_alu};
    if (src == 4'hF) return rfv;
    for (int k = 0; k < 5; k++)
      if (ids[k] == src) return vals[k];
    return rfv;
  endfunction

  function automatic logic [63:0] exp_a();
    if (dec_op == 4'h7 || dec_op == 4'h8) return dec_pc_inc;
    return model(dec_src_a, rf_a);
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic settle();
    @(negedge clk);
    #1;
  endtask

  task automatic base();
    dec_op = 4'h6; dec_pc_inc = 64'h1000; rf_a = 64'hAAAA; rf_b = 64'hBBBB;
    ex_res = 64'h11; mem_ld = 64'h22; mem_alu = 64'h33; wb_ld = 64'h44; wb_alu = 64'h55;
    ex_dst = 4'hF; mem_dst_ld = 4'hF; mem_dst_alu = 4'hF; wb_dst_ld = 4'hF; wb_dst_alu = 4'hF;
    dec_src_a = 4'h2; dec_src_b = 4'h3;
  endtask

  initial begin
    #(CLK_PERIOD*200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hang expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd12345));
    base(); settle();
    check("R4 idle A", opnd_a, 64'hAAAA);
    check("R4 idle B", opnd_b, 64'hBBBB);

    base(); wb_dst_alu = 4'h2; wb_dst_ld = 4'h2; mem_dst_alu = 4'h2; mem_dst_ld = 4'h2; ex_dst = 4'h2; settle();
    check("R2 ex rung", opnd_a, 64'h11);
    base(); wb_dst_alu = 4'h2; wb_dst_ld = 4'h2; mem_dst_alu = 4'h2; mem_dst_ld = 4'h2; settle();
    check("R2 mem load rung", opnd_a, 64'h22);
    base(); wb_dst_alu = 4'h2; wb_dst_ld = 4'h2; mem_dst_alu = 4'h2; settle();
    check("R2 mem alu rung", opnd_a, 64'h33);
    base(); wb_dst_alu = 4'h2; wb_dst_ld = 4'h2; settle();
    check("R2 wb load rung", opnd_a, 64'h44);
    base(); wb_dst_alu = 4'h2; settle();
    check("R2 wb alu rung", opnd_a, 64'h55);

    base(); mem_dst_alu = 4'h3; wb_dst_ld = 4'h3; settle();
    check("R3 youngest wins B", opnd_b, 64'h33);

    base(); dec_op = 4'h8; ex_dst = 4'h2; settle();
    check("R1 call A", opnd_a, 64'h1000);
    base(); dec_op = 4'h7; ex_dst = 4'h3; settle();
    check("R1 jump A", opnd_a, 64'h1000);
    check("R6 jump B still forwarded", opnd_b, 64'h11);

    base(); dec_src_a = 4'hF; dec_src_b = 4'hF; settle();
    check("R5 noreg A", opnd_a, 64'hAAAA);
    check("R5 noreg B", opnd_b, 64'hBBBB);

    base(); ex_dst = 4'hF; dec_src_a = 4'h2; wb_dst_alu = 4'h2; settle();
    check("R7 cancelled ex", opnd_a, 64'h55);

    for (int i = 0; i < 3000; i++) begin
      dec_op = 4'($urandom % 16);
      dec_pc_inc = {$urandom, $urandom};
      rf_a = {$urandom, $urandom}; rf_b = {$urandom, $urandom};
      ex_res = {$urandom, $urandom}; mem_ld = {$urandom, $urandom};
      mem_alu = {$urandom, $urandom}; wb_ld = {$urandom, $urandom}; wb_alu = {$urandom, $urandom};
      dec_src_a = ($urandom % 5 == 0) ? 4'hF : 4'($urandom % 4);
      dec_src_b = ($urandom % 5 == 0) ? 4'hF : 4'($urandom % 4);
      ex_dst      = ($urandom % 4 == 0) ? 4'hF : 4'($urandom % 4);
      mem_dst_ld  = ($urandom % 3 == 0) ? 4'hF : 4'($urandom % 4);
      mem_dst_alu = ($urandom % 3 == 0) ? 4'hF : 4'($urandom % 4);
      wb_dst_ld   = ($urandom % 3 == 0) ? 4'hF : 4'($urandom % 4);
      wb_dst_alu  = ($urandom % 3 == 0) ? 4'hF : 4'($urandom % 4);
      #1;
      check("R8 random A", opnd_a, exp_a());
      check("R6 random B", opnd_b, model(dec_src_b, rf_b));
      @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule